// File: doc/BRIEF.md
# Pseudo-Random-Pointer Synchronous FIFO

A single-clock first-in first-out buffer whose read and write addresses are kept in linear feedback shift registers rather than binary counters. Each address register steps by shifting one place toward its MSB and taking the XNOR of a fixed set of tap bits into the LSB. With a tap set of maximum period, the addresses visit every value except all-ones before repeating. Advancing a pointer therefore never involves a carry chain, and the storage array only needs one entry per reachable address.

A producer presents a word with `wr_valid_i` and sees `full_o`. A consumer raises `rd_pop_i` and sees `empty_o`. The popped word appears on a registered output. The pointer width `PTR_W` selects the tap set from a built-in table of maximum-period polynomials for widths 3 to 12. The usable depth is 2^PTR_W-2 words.

Top module: `lfsr_fifo`

## Requirements
- R1: While `rst_ni` is low and after it is released, both pointers are all zeros, `empty_o` is 1, `full_o` is 0 and `rd_data_o` is 0.
- R2: A pointer that advances shifts its bits one place toward the MSB and takes as its new LSB the XNOR of its tap bits (bits 3 and 0 when `PTR_W`=4). The tap set has maximum period, so the write pointer addresses 2^PTR_W-1 distinct locations before repeating. Observed at the ports, 2^PTR_W-2 successive writes are all held and are returned intact and in order.
- R3: Neither pointer ever holds the all-ones value, and the storage has 2^PTR_W-1 entries. Data stays intact when the pointers pass through their whole cycle.
- R4: `empty_o` is 1 exactly when the read pointer equals the write pointer, which is the case when no words are stored.
- R5: `full_o` is 1 exactly when the next value of the write pointer equals the read pointer, which is the case when 2^PTR_W-2 words are stored (14 when `PTR_W`=4).
- R6: A write presented while `full_o` is 1 is dropped. It moves no pointer, and the dropped word never appears at the output.
- R7: A pop presented while `empty_o` is 1 is ignored. It moves no pointer, and `rd_data_o` keeps its value.
- R8: An accepted write and an accepted pop in the same cycle advance both pointers and leave the fill level unchanged. While full, a combined request performs the pop and drops the write.
- R9: `rd_data_o` is registered. It takes the word at the read pointer on the clock edge that accepts a pop and holds its value on every other edge.
- R10: Words leave in the order they were accepted over an arbitrary mix of writes and pops, across many pointer wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | DATA_W | Word to store |
| wr_valid_i | input | 1 | Write request |
| full_o | output | 1 | No free slot; writes are dropped |
| rd_pop_i | input | 1 | Pop request |
| rd_data_o | output | DATA_W | Most recently popped word |
| empty_o | output | 1 | No stored word; pops are ignored |

## Verification
The hardest case to reach from the ports is a pointer that wraps past the point where an all-ones address would have appeared while data is still in flight. That wrap is the only place where a wrong tap set, a reachable lock-up value or an off-by-one array size would show. The stimulus first fills the buffer to exactly 14 words and pushes against the full flag. It then holds a partial fill level through long runs of combined writes and pops, so both pointers go around the 15-state cycle several times with data in the buffer. A pseudo-random mix of requests follows, and a scoreboard queue checks every returned word.

// File: rtl/lfsr_fifo_pkg.sv
package lfsr_fifo_pkg;

  // Feedback mask for a left-shifting XNOR register of width w.
  // Bit w-1 is always a tap; the others come from a maximum-period polynomial.
  function automatic logic [31:0] tap_mask(input int unsigned w);
    logic [31:0] m;
    case (w)
      3:       m = 32'h0000_0005;
      4:       m = 32'h0000_0009;
      5:       m = 32'h0000_0012;
      6:       m = 32'h0000_0021;
      7:       m = 32'h0000_0041;
      8:       m = 32'h0000_008E;
      9:       m = 32'h0000_0108;
      10:      m = 32'h0000_0204;
      11:      m = 32'h0000_0402;
      12:      m = 32'h0000_0CA0;
      default: m = 32'h0000_0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lfsr_ptr.sv
module lfsr_ptr #(
  parameter int unsigned        W    = 4,
  parameter logic [W-1:0]       TAPS = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] ptr_o,
  output logic [W-1:0] nxt_o
);

  logic [W-1:0] ptr_q;

  // XNOR feedback: all-zeros is a legal start, all-ones is the lock-up state
  assign nxt_o = {ptr_q[W-2:0], ~^(ptr_q & TAPS)};
  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= nxt_o;
  end

endmodule

// File: rtl/lfsr_fifo_mem.sv
module lfsr_fifo_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DEPTH  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/lfsr_fifo.sv
module lfsr_fifo #(
  parameter int unsigned PTR_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_valid_i,
  output logic              full_o,
  input  logic              rd_pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o
);

  // all-ones address is unreachable, so one entry fewer than 2^PTR_W
  localparam int unsigned      DEPTH = (1 << PTR_W) - 1;
  localparam logic [PTR_W-1:0] TAPS  = PTR_W'(lfsr_fifo_pkg::tap_mask(PTR_W));

  if (lfsr_fifo_pkg::tap_mask(PTR_W) == 32'd0) begin : g_bad_width
    $error("lfsr_fifo: PTR_W outside supported range 3..12");
  end

  logic [PTR_W-1:0] wr_ptr, wr_nxt, rd_ptr, rd_nxt;
  logic             push, pop;

  assign empty_o = (rd_ptr == wr_ptr);
  assign full_o  = (wr_nxt == rd_ptr);
  assign push    = wr_valid_i & ~full_o;
  assign pop     = rd_pop_i & ~empty_o;

  lfsr_ptr #(.W(PTR_W), .TAPS(TAPS)) u_wr_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (push),
    .ptr_o (wr_ptr),
    .nxt_o (wr_nxt)
  );

  lfsr_ptr #(.W(PTR_W), .TAPS(TAPS)) u_rd_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (pop),
    .ptr_o (rd_ptr),
    .nxt_o (rd_nxt)
  );

  lfsr_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(PTR_W), .DEPTH(DEPTH)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (push),
    .waddr_i(wr_ptr),
    .wdata_i(wr_data_i),
    .re_i   (pop),
    .raddr_i(rd_ptr),
    .rdata_o(rd_data_o)
  );

  logic unused_rd_nxt;
  assign unused_rd_nxt = ^rd_nxt;

endmodule

// File: rtl/lfsr_fifo_chk.sv
module lfsr_fifo_chk #(
  parameter int unsigned PTR_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              rd_pop_i,
  input logic              full_o,
  input logic              empty_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic [PTR_W-1:0]  rd_ptr
);

  // R3
  no_ones_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr != '1) && (rd_ptr != '1));

  // R2
  wr_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !full_o) |=> (wr_ptr[PTR_W-1:1] == $past(wr_ptr[PTR_W-2:0])));

  // R4
  push_clears_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !full_o) |=> !empty_o);

  // R5
  pop_clears_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pop_i && !empty_o) |=> !full_o);

  // R6
  full_blocks_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> $stable(wr_ptr));

  // R7
  empty_blocks_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |=> ($stable(rd_ptr) && $stable(rd_data_o)));

  // R8
  both_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !full_o && rd_pop_i && !empty_o) |=>
      (!empty_o && !full_o && (wr_ptr != $past(wr_ptr)) && (rd_ptr != $past(rd_ptr))));

  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_pop_i && !empty_o) |=> $stable(rd_data_o));

  // R4, R5
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

endmodule

bind lfsr_fifo lfsr_fifo_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_valid_i(wr_valid_i),
  .rd_pop_i  (rd_pop_i),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .rd_data_o (rd_data_o),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr)
);

// File: tb/tb_lfsr_fifo.sv
module tb_lfsr_fifo;

  localparam int unsigned PTR_W  = 4;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CAP    = (1 << PTR_W) - 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              wr_valid_i = 1'b0;
  logic              rd_pop_i = 1'b0;
  logic              full_o, empty_o;
  logic [DATA_W-1:0] rd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] exp_q[$];
  logic              mon_v = 1'b0;
  logic [DATA_W-1:0] mon_exp = '0;
  string             mon_tag = "R9";
  logic [DATA_W-1:0] last_rd = '0;

  always #5 clk = ~clk;

  lfsr_fifo #(.PTR_W(PTR_W), .DATA_W(DATA_W)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_data_i (wr_data_i),
    .wr_valid_i(wr_valid_i),
    .full_o    (full_o),
    .rd_pop_i  (rd_pop_i),
    .rd_data_o (rd_data_o),
    .empty_o   (empty_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // Driver: checks flags against the model, drives one cycle, updates the scoreboard
  task automatic step(input bit p, input logic [DATA_W-1:0] d, input bit q, input string tag);
    int sz;
    @(negedge clk);
    sz = exp_q.size();
    chk(empty_o == (sz == 0), "R4", int'(empty_o), int'(sz == 0));
    chk(full_o == (sz == CAP), "R5", int'(full_o), int'(sz == CAP));
    wr_valid_i = p;
    wr_data_i  = d;
    rd_pop_i   = q;
    if (q && sz != 0) begin
      mon_exp = exp_q.pop_front();
      mon_v   = 1'b1;
      mon_tag = tag;
    end else begin
      mon_v   = 1'b0;
      mon_tag = (q && sz == 0) ? "R7" : "R9";
    end
    if (p && sz != CAP) exp_q.push_back(d);
    @(posedge clk);
  endtask

  // Monitor: compares registered read data shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && !done) begin
        if (mon_v) begin
          chk(rd_data_o == mon_exp, mon_tag, int'(rd_data_o), int'(mon_exp));
          last_rd = mon_exp;
        end else begin
          chk(rd_data_o == last_rd, mon_tag, int'(rd_data_o), int'(last_rd));
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int unsigned seed;
    logic [DATA_W-1:0] val;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state before release
    chk(empty_o == 1'b1, "R1", int'(empty_o), 1);
    chk(full_o == 1'b0, "R1", int'(full_o), 0);
    chk(rd_data_o == '0, "R1", int'(rd_data_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty_o == 1'b1 && full_o == 1'b0 && rd_data_o == '0, "R1",
        int'({empty_o, full_o}), 2);

    // R7: pops on an empty buffer
    repeat (3) step(1'b0, '0, 1'b1, "R7");

    // R2 R5: fill to capacity, every address distinct
    for (int i = 0; i < CAP; i++) step(1'b1, DATA_W'(8'h10 + i), 1'b0, "R2");
    // R6: writes against full are dropped
    repeat (3) step(1'b1, 8'hEE, 1'b0, "R6");
    // R8: combined request while full pops and drops the write
    step(1'b1, 8'hAA, 1'b1, "R8");
    step(1'b0, '0, 1'b0, "R9");
    // R2 R6: drain, dropped words must not appear
    while (exp_q.size() != 0) step(1'b0, '0, 1'b1, "R2");
    step(1'b0, '0, 1'b1, "R7");

    // R3 R8: hold a level while both pointers wrap many times
    for (int i = 0; i < 5; i++) step(1'b1, DATA_W'(8'h40 + i), 1'b0, "R3");
    for (int i = 0; i < 60; i++) step(1'b1, DATA_W'(8'h60 + i), 1'b1, "R8");
    while (exp_q.size() != 0) step(1'b0, '0, 1'b1, "R3");

    // R10: pseudo-random mix
    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      val  = seed[23:16];
      step(seed[28] | seed[29], val, seed[30] | (seed[27] & seed[26]), "R10");
    end
    while (exp_q.size() != 0) step(1'b0, '0, 1'b1, "R10");
    step(1'b0, '0, 1'b0, "R9");
    step(1'b0, '0, 1'b0, "R9");
    summary();
  end

endmodule